// File: doc/BRIEF.md
# Mixed-Domain Scan Chain with Lockup Latches

This block is a scan chain of MUX-D cells that spans three clock domains: cells clocked on the falling edge of a primary clock, cells on a second, independent clock, and cells on the rising edge of the primary clock. Each cell either loads its functional data input or the output of the cell before it, as chosen by a shared scan-enable. The cells form one contiguous subchain per domain. The subchains are ordered so that the latest-arriving clock sits closest to scan_in. A level-sensitive lockup latch sits at each boundary between domains. Together with this ordering, the latches keep shifting correct while the two clocks are skewed against each other.

The second domain's clock is gated by a functional enable. In test mode a multiplexer replaces the gated clock with the ungated system clock. This keeps the scan path clocked no matter what the gating logic does. An active-low asynchronous reset clears every cell and latch. The captured contents of the whole chain are brought out in chain order.

Top module: `mdscan_chain`

## Requirements
- R1: While rst_n is low, every cell and lockup latch is cleared at once, so cap_q and scan_out read 0.
- R2: With scan_en high and test_mode high, a bit driven on scan_in before the falling edge of clk_a in period P appears on scan_out in period P+N (N = total cell count, 8 by default). The returned sequence has no bit lost or repeated for any skew between clk_a and clk_b below half a period.
- R3: Chain order is fixed. cap_q[0..NEG_CELLS-1] are the falling-edge cells, nearest scan_in. The next SEC_CELLS bits are the second-domain cells. The top POS_CELLS bits are the rising-edge clk_a cells. cap_q[N-1] drives scan_out, so an unload presents cap_q[N-1] first and cap_q[0] last.
- R4: With scan_en low, cell i loads func_d[i] on its own active clock edge.
- R5: The falling-edge cells change only on the falling edge of clk_a. They keep their value across the rising edge.
- R6: A lockup latch at a domain boundary is transparent while its upstream subchain's clock pin is low, and holds across that clock's rising edge. The downstream cell therefore takes the value the upstream cell had before the current shift.
- R7: With test_mode low and sec_clk_en low, the second-domain cells receive no clock edge and keep their contents.
- R8: With test_mode high, the second-domain cells are clocked by clk_b whatever the level of sec_clk_en.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Primary clock; rising edge for the tail subchain, falling edge for the head subchain |
| clk_b | input | 1 | Independent clock of the middle subchain |
| rst_n | input | 1 | Asynchronous active-low clear |
| test_mode | input | 1 | Selects ungated clk_b for the middle subchain |
| sec_clk_en | input | 1 | Functional gate enable for clk_b |
| scan_en | input | 1 | 1: cells shift; 0: cells load func_d |
| scan_in | input | 1 | Serial input at the head of the chain |
| func_d | input | N | Functional data, one bit per cell in chain order |
| scan_out | output | 1 | Serial output, last cell of the chain |
| cap_q | output | N | Contents of all cells in chain order |

## Verification
Rising-edge cells and second-domain cells show a capture at the first sample point after the next rising edge. Falling-edge cells show it only one period later, because their edge comes half a period afterwards. A scan_in bit reaches scan_out N periods after the period in which it is driven. Every period, the bench samples 2.3 ns after the reference rising edge, when all skewed rising edges are done and no falling edge has come yet. It changes inputs at 4.7 ns, after every falling edge and before the next rising edge. Each expected value is therefore placed at one exact period count for any skew from 0 to 2 ns on either clock.

// File: rtl/msc_pkg.sv
`timescale 1ns/1ps
package msc_pkg;

  typedef enum logic [1:0] {
    DOM_NEG = 2'd0,
    DOM_SEC = 2'd1,
    DOM_POS = 2'd2
  } dom_e;

  function automatic int chain_len(input int nn, input int ns, input int np);
    return nn + ns + np;
  endfunction

  // Domain of the cell at chain position idx (0 = nearest scan_in).
  function automatic dom_e dom_of(input int idx, input int nn, input int ns);
    if (idx < nn)      return DOM_NEG;
    if (idx < nn + ns) return DOM_SEC;
    return DOM_POS;
  endfunction

  // A lockup latch precedes the first cell of every later subchain.
  function automatic bit is_boundary(input int idx, input int nn, input int ns);
    return (idx == nn) || (idx == nn + ns);
  endfunction

endpackage

// File: rtl/msc_cell.sv
`timescale 1ns/1ps
module msc_cell #(
  parameter bit FALL_EDGE = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sel_scan,
  input  logic func_d,
  input  logic scan_d,
  output logic q
);
  logic mux_d;
  assign mux_d = sel_scan ? scan_d : func_d;

  generate
    if (FALL_EDGE) begin : g_fall
      always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) q <= 1'b0;
        else        q <= mux_d;
      end
    end else begin : g_rise
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= 1'b0;
        else        q <= mux_d;
      end
    end
  endgenerate
endmodule

// File: rtl/msc_lockup.sv
`timescale 1ns/1ps
module msc_lockup (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  // Open while the upstream clock is low, closed across its rising edge.
  always_latch begin
    if (!rst_n)    q = 1'b0;
    else if (!clk) q = d;
  end
endmodule

// File: rtl/msc_clk_sel.sv
`timescale 1ns/1ps
module msc_clk_sel (
  input  logic clk,
  input  logic gate_en,
  input  logic test_mode,
  output logic clk_out
);
  logic en_l;
  logic gated;

  // Glitch-free gate: the enable is frozen while clk is high.
  always_latch begin
    if (!clk) en_l = gate_en;
  end

  assign gated   = clk & en_l;
  assign clk_out = test_mode ? clk : gated;
endmodule

// File: rtl/mdscan_chain.sv
`timescale 1ns/1ps
module mdscan_chain #(
  parameter int NEG_CELLS = 2,
  parameter int SEC_CELLS = 3,
  parameter int POS_CELLS = 3,
  localparam int N = msc_pkg::chain_len(NEG_CELLS, SEC_CELLS, POS_CELLS)
) (
  input  logic         clk_a,
  input  logic         clk_b,
  input  logic         rst_n,
  input  logic         test_mode,
  input  logic         sec_clk_en,
  input  logic         scan_en,
  input  logic         scan_in,
  input  logic [N-1:0] func_d,
  output logic         scan_out,
  output logic [N-1:0] cap_q
);
  localparam int SEC_HEAD = NEG_CELLS;
  localparam int POS_HEAD = NEG_CELLS + SEC_CELLS;

  logic         sec_clk;
  logic [N-1:0] chain_q;
  logic [N-1:0] link_d;
  logic         lk_neg_q;
  logic         lk_sec_q;
  logic         pos_tail_func;

  msc_clk_sel u_sec_clk (
    .clk       (clk_b),
    .gate_en   (sec_clk_en),
    .test_mode (test_mode),
    .clk_out   (sec_clk)
  );

  generate
    for (genvar i = 0; i < N; i++) begin : g_pos
      localparam msc_pkg::dom_e DOM = msc_pkg::dom_of(i, NEG_CELLS, SEC_CELLS);

      if (i == 0) begin : g_head
        assign link_d[i] = scan_in;
      end else if (msc_pkg::is_boundary(i, NEG_CELLS, SEC_CELLS)) begin : g_lock
        localparam msc_pkg::dom_e UP = msc_pkg::dom_of(i - 1, NEG_CELLS, SEC_CELLS);
        logic up_clk;
        if (UP == msc_pkg::DOM_SEC) begin : g_up_sec
          assign up_clk = sec_clk;
        end else begin : g_up_a
          assign up_clk = clk_a;
        end
        msc_lockup u_lock (
          .clk   (up_clk),
          .rst_n (rst_n),
          .d     (chain_q[i-1]),
          .q     (link_d[i])
        );
      end else begin : g_wire
        assign link_d[i] = chain_q[i-1];
      end

      if (DOM == msc_pkg::DOM_NEG) begin : g_neg
        msc_cell #(.FALL_EDGE(1'b1)) u_cell (
          .clk (clk_a), .rst_n (rst_n), .sel_scan (scan_en),
          .func_d (func_d[i]), .scan_d (link_d[i]), .q (chain_q[i])
        );
      end else if (DOM == msc_pkg::DOM_SEC) begin : g_sec
        msc_cell #(.FALL_EDGE(1'b0)) u_cell (
          .clk (sec_clk), .rst_n (rst_n), .sel_scan (scan_en),
          .func_d (func_d[i]), .scan_d (link_d[i]), .q (chain_q[i])
        );
      end else begin : g_rise
        msc_cell #(.FALL_EDGE(1'b0)) u_cell (
          .clk (clk_a), .rst_n (rst_n), .sel_scan (scan_en),
          .func_d (func_d[i]), .scan_d (link_d[i]), .q (chain_q[i])
        );
      end
    end
  endgenerate

  // Named boundary events for the checker.
  assign lk_neg_q      = link_d[SEC_HEAD];
  assign lk_sec_q      = link_d[POS_HEAD];
  assign pos_tail_func = func_d[N-1];

  assign cap_q    = chain_q;
  assign scan_out = chain_q[N-1];
endmodule

// File: rtl/mdscan_chain_chk.sv
`timescale 1ns/1ps
module mdscan_chain_chk #(
  parameter int NEG_CELLS = 2,
  parameter int SEC_CELLS = 3,
  parameter int POS_CELLS = 3,
  localparam int N = msc_pkg::chain_len(NEG_CELLS, SEC_CELLS, POS_CELLS)
) (
  input logic         clk_a,
  input logic         clk_b,
  input logic         sec_clk,
  input logic         rst_n,
  input logic         test_mode,
  input logic         sec_clk_en,
  input logic         scan_en,
  input logic         scan_in,
  input logic         pos_tail_func,
  input logic [N-1:0] chain_q,
  input logic         lk_neg_q,
  input logic         lk_sec_q
);
  localparam int SEC_HEAD = NEG_CELLS;
  localparam int POS_HEAD = NEG_CELLS + SEC_CELLS;

  AST_HEAD_SHIFT: assert property (@(negedge clk_a) disable iff (!rst_n)
    scan_en |=> chain_q[0] == $past(scan_in)); // R2

  AST_TAIL_CAPTURE: assert property (@(posedge clk_a) disable iff (!rst_n)
    !scan_en |=> chain_q[N-1] == $past(pos_tail_func)); // R4

  AST_GATED_HOLD: assert property (@(posedge clk_b) disable iff (!rst_n)
    (!test_mode && !sec_clk_en) |=> $stable(chain_q[POS_HEAD-1:SEC_HEAD])); // R7

  generate
    for (genvar i = 1; i < N; i++) begin : g_link
      if (i < SEC_HEAD) begin : g_neg
        AST_NEG_STEP: assert property (@(negedge clk_a) disable iff (!rst_n)
          scan_en |=> chain_q[i] == $past(chain_q[i-1])); // R5
      end else if (i == SEC_HEAD) begin : g_sec_in
        AST_SEC_ENTRY: assert property (@(posedge sec_clk) disable iff (!rst_n)
          scan_en |=> chain_q[i] == $past(lk_neg_q)); // R6
      end else if (i < POS_HEAD) begin : g_sec
        AST_SEC_STEP: assert property (@(posedge sec_clk) disable iff (!rst_n)
          scan_en |=> chain_q[i] == $past(chain_q[i-1])); // R2
      end else if (i == POS_HEAD) begin : g_pos_in
        AST_POS_ENTRY: assert property (@(posedge clk_a) disable iff (!rst_n)
          scan_en |=> chain_q[i] == $past(lk_sec_q)); // R6
      end else begin : g_pos
        AST_POS_STEP: assert property (@(posedge clk_a) disable iff (!rst_n)
          scan_en |=> chain_q[i] == $past(chain_q[i-1])); // R2
      end
    end
  endgenerate
endmodule

bind mdscan_chain mdscan_chain_chk #(
  .NEG_CELLS (NEG_CELLS),
  .SEC_CELLS (SEC_CELLS),
  .POS_CELLS (POS_CELLS)
) chk_i (
  .clk_a         (clk_a),
  .clk_b         (clk_b),
  .sec_clk       (sec_clk),
  .rst_n         (rst_n),
  .test_mode     (test_mode),
  .sec_clk_en    (sec_clk_en),
  .scan_en       (scan_en),
  .scan_in       (scan_in),
  .pos_tail_func (pos_tail_func),
  .chain_q       (chain_q),
  .lk_neg_q      (lk_neg_q),
  .lk_sec_q      (lk_sec_q)
);

// File: tb/mdscan_chain_tb_top.sv
`timescale 1ns/1ps
module mdscan_chain_tb_top;
  localparam int NN = 2;
  localparam int NS = 3;
  localparam int NP = 3;
  localparam int N  = NN + NS + NP;

  logic clk_ref = 1'b0;
  logic clk_a   = 1'b0;
  logic clk_b   = 1'b0;
  real  da = 0.0;
  real  db = 0.0;

  logic         rst_n = 1'b0;
  logic         test_mode = 1'b1;
  logic         sec_clk_en = 1'b0;
  logic         scan_en = 1'b1;
  logic         scan_in = 1'b0;
  logic [N-1:0] func_d = '0;
  logic         scan_out;
  logic [N-1:0] cap_q;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  // 200 MHz reference; each domain clock is a delayed copy of it.
  always #2.5 clk_ref = ~clk_ref;
  always @(clk_ref) clk_a <= #(da) clk_ref;
  always @(clk_ref) clk_b <= #(db) clk_ref;

  mdscan_chain #(.NEG_CELLS(NN), .SEC_CELLS(NS), .POS_CELLS(NP)) dut_i (
    .clk_a (clk_a), .clk_b (clk_b), .rst_n (rst_n),
    .test_mode (test_mode), .sec_clk_en (sec_clk_en),
    .scan_en (scan_en), .scan_in (scan_in), .func_d (func_d),
    .scan_out (scan_out), .cap_q (cap_q)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  // Sample point: all skewed rising edges done, no falling edge yet.
  task automatic next_sample();
    @(posedge clk_ref);
    #2.3;
  endtask

  // Drive point: all falling edges done, next rising edge not yet.
  task automatic to_drive();
    #2.4;
  endtask

  function automatic logic pat_bit(input int t, input int seed);
    return (((t * t + seed * t + seed) >> 1) % 2) == 1;
  endfunction

  task automatic shift_run(input real a, input real b, input int seed, input int len);
    da = a; db = b;
    scan_en = 1'b1; test_mode = 1'b1;
    for (int t = 0; t < len + N; t++) begin
      scan_in = (t < len) ? pat_bit(t, seed) : 1'b0;
      next_sample();
      if (t + 1 >= N && t + 1 - N < len)
        chk(scan_out == pat_bit(t + 1 - N, seed), "R2 R6 shift sequence",
            32'(scan_out), 32'(pat_bit(t + 1 - N, seed)));
      to_drive();
    end
  endtask

  task automatic capture_run(input logic [N-1:0] v, input bit tm, input bit en);
    logic [NS-1:0] bprev;
    logic [NN-1:0] nprev;
    logic [NS-1:0] bexp;
    logic [N-1:0]  e;
    bprev = cap_q[NN+NS-1:NN];
    nprev = cap_q[NN-1:0];
    bexp  = (tm || en) ? v[NN+NS-1:NN] : bprev;
    e     = {v[N-1:NN+NS], bexp, v[NN-1:0]};
    scan_en = 1'b0; func_d = v; test_mode = tm; sec_clk_en = en;
    next_sample();
    chk(cap_q[N-1:NN+NS] == v[N-1:NN+NS], "R4 rising cells capture",
        32'(cap_q[N-1:NN+NS]), 32'(v[N-1:NN+NS]));
    chk(cap_q[NN-1:0] == nprev, "R5 falling cells wait",
        32'(cap_q[NN-1:0]), 32'(nprev));
    chk(cap_q[NN+NS-1:NN] == bexp, tm ? "R8 bypass clock" : "R7 gated clock",
        32'(cap_q[NN+NS-1:NN]), 32'(bexp));
    chk(scan_out == e[N-1], "R3 unload first bit", 32'(scan_out), 32'(e[N-1]));
    to_drive();
    scan_en = 1'b1; scan_in = 1'b0; test_mode = 1'b1; sec_clk_en = 1'b0;
    for (int m = 1; m < N; m++) begin
      next_sample();
      if (m == 1)
        chk(cap_q[NN-1:0] == v[NN-1:0], "R4 R5 falling cells capture",
            32'(cap_q[NN-1:0]), 32'(v[NN-1:0]));
      chk(scan_out == e[N-1-m], "R3 unload order", 32'(scan_out), 32'(e[N-1-m]));
      to_drive();
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
  endtask

  initial begin
    #(200000 * 5.0);
    if (!done) begin
      n_bad++;
      $display("FAIL R2 watchdog: got 0 expected 1");
      summary();
      $finish;
    end
  end

  initial begin
    // R1: reset state
    next_sample();
    next_sample();
    chk(cap_q == '0, "R1 reset cells", 32'(cap_q), 32'h0);
    chk(scan_out == 1'b0, "R1 reset scan_out", 32'(scan_out), 32'h0);
    to_drive();
    rst_n = 1'b1;

    // R2 R6: shifting under several skews of both clocks
    shift_run(0.0, 0.0, 3, 40);
    shift_run(0.0, 2.0, 7, 40);
    shift_run(2.0, 0.0, 11, 40);
    shift_run(1.0, 1.9, 5, 40);
    shift_run(1.9, 0.3, 9, 40);

    // R3 R4 R5 R8: every capture pattern, skew varied per pattern
    for (int v = 0; v < (1 << N); v++) begin
      da = v[0] ? 1.5 : 0.0;
      db = v[1] ? 1.8 : 0.2;
      capture_run(N'(v), 1'b1, 1'b1);
    end

    // R7 R8: gated clock behaviour
    da = 0.5; db = 1.0;
    capture_run(8'hFF, 1'b0, 1'b0);
    capture_run(8'h5A, 1'b1, 1'b0);
    capture_run(8'hFF, 1'b0, 1'b1);

    // R1: asynchronous clear of loaded contents
    scan_en = 1'b0; func_d = 8'hFF;
    next_sample();
    chk(cap_q[N-1:NN] != '0, "R1 preload nonzero", 32'(cap_q), 32'h1);
    to_drive();
    scan_en = 1'b1;
    rst_n = 1'b0;
    #0.1;
    chk(cap_q == '0, "R1 async clear", 32'(cap_q), 32'h0);
    chk(scan_out == 1'b0, "R1 async clear scan_out", 32'(scan_out), 32'h0);
    #0.2;
    rst_n = 1'b1;

    done = 1'b1;
    summary();
    $finish;
  end
endmodule